// File: doc/BRIEF.md
# Touch ADC Conversion Sequencer

This block is the sequencing core of a touch-screen and sensor ADC controller. The host writes a control word holding the function it wants next, a resolution index, an enable bit and a filter byte. The block then decides on its own when to start a conversion burst. That decision depends on the requested function, on the pen-pressure level, and on whether any earlier result is still unread. A burst holds the block busy for a fixed number of clock cycles. When it finishes, the block sets the data-available bits that belong to the function it ran.

Data reads from a neighbouring register file return per-channel clear strobes, and each strobe drops its channel's bit. An active-low interrupt pin reports one of three conditions, chosen by a small pin-mode register. The block does not hold sample values or model the analog front end. It only publishes the active function and resolution, so that a sampler can scale its raw results.

Top module: `adc_seq_core`

## Requirements
- R1: After reset or soft reset the block is disabled. Busy is 0, data-available is 0, the interrupt pin is high, the next function, resolution and filter are 0, and the pin mode is 2.
- R2: A control write takes bit 14 as disable (1 = disabled), bits 13:10 as the next function, bits 9:8 as the resolution index and bits 7:0 as the filter. Bit 15 is kept on `host_ctl`. The status word reads {pen level, not busy, next function, next resolution, filter} from bit 15 down to bit 0.
- R3: A burst starts only when the block is enabled, not busy and has no data bit set. Functions 1 to 5 also need the pen pressed. Functions 6 to 12 start whatever the pen does. Functions 0 and 13 to 15 never start. No burst starts in a cycle that carries a control write or a soft reset.
- R4: Busy stays high for exactly BUSY_CYCLES cycles. At the end, the function's mask is ORed into data-available. The masks are: 1→0x0600, 2→0x0780, 3→0x0400, 4→0x0200, 5→0x0180, 6→0x0040, 7→0x0030, 8→0x0010, 9→0x0010, 10→0x0004, 11→0x0070, 12→0x0002, and 0 for all other functions.
- R5: When a burst starts, the next function and resolution are copied into the active ones, and they hold for the whole burst. Resolution index 0, 1, 2, 3 gives 12, 8, 10, 12 bits on `act_bits`.
- R6: Functions 3 to 8, 10 and 12 are single-shot. While any data bit is set, they clear the enable, and functions 3 to 5 do so only while the pen is pressed. Functions 9 and 11 are continuous and start again once all data bits have been cleared.
- R7: A `rd_clear` strobe clears exactly the data-available bits it names, one cycle later, and leaves the other bits alone.
- R8: The interrupt pin is registered and active low. Its source is the pen level in mode 0, any data available in mode 1, and pen pressed with no data pending in modes 2 and 3.
- R9: A control write that disables the block while it is busy aborts the burst. Busy is low on the next cycle and no data bit is set.
- R10: A key write of 0xBB00 performs the soft reset of R1. A key write of any other value changes nothing.
- R11: While the block is disabled, the interrupt pin is held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pen_down | input | 1 | Pen-pressure level, 1 = pressed |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_data | input | 16 | Control word |
| pin_wr | input | 1 | Pin-mode write strobe |
| pin_data | input | 2 | Pin-mode value |
| key_wr | input | 1 | Soft-reset key write strobe |
| key_data | input | 16 | Soft-reset key value |
| rd_clear | input | 16 | Per-channel data-available clear strobes |
| busy | output | 1 | Conversion burst in progress |
| avail | output | 16 | Data-available vector |
| irq_n | output | 1 | Active-low interrupt |
| act_func | output | 4 | Function of the current or most recent burst |
| act_res | output | 2 | Resolution index of the current or most recent burst |
| act_bits | output | 5 | Result width in bits for `act_res` |
| status | output | 16 | Status word |
| host_ctl | output | 1 | Stored host-control bit |

## Verification
The assertions assume that `pen_down` and the write strobes are synchronous to `clk`. They also assume that a soft reset or a control write has priority over a burst start in the same cycle. The abort check therefore does not need to consider a restart racing the disable. The bench changes every input only on falling edges and holds each strobe for one cycle. It always waits until a burst has finished or been aborted before it judges the data bits, so each property sees only the orderings the design defines.

// File: rtl/adc_seq_pkg.sv
// Shared constants, types and per-function lookup tables for the conversion sequencer.
package adc_seq_pkg;

    localparam int WORD_W  = 16;
    localparam int FUNC_W  = 4;
    localparam int RES_W   = 2;
    localparam int FILT_W  = 8;
    localparam int PMODE_W = 2;
    localparam int BITS_W  = 5;

    localparam logic [WORD_W-1:0] RESET_KEY = 16'hBB00;

    // Interrupt source selection.
    typedef enum logic [PMODE_W-1:0] {
        PIN_PEN      = 2'd0,
        PIN_DATA     = 2'd1,
        PIN_PEN_IDLE = 2'd2,
        PIN_SPARE    = 2'd3
    } pin_mode_e;

    // Start behaviour of one function code.
    typedef struct packed {
        logic can_start;
        logic needs_pen;
        logic one_shot;
    } fn_attr_t;

    // Start class of each function code.
    function automatic fn_attr_t fn_attr(input logic [FUNC_W-1:0] f);
        fn_attr_t a;
        case (f)
            4'd1, 4'd2:                      a = '{can_start: 1'b1, needs_pen: 1'b1, one_shot: 1'b0};
            4'd3, 4'd4, 4'd5:                a = '{can_start: 1'b1, needs_pen: 1'b1, one_shot: 1'b1};
            4'd6, 4'd7, 4'd8, 4'd10, 4'd12:  a = '{can_start: 1'b1, needs_pen: 1'b0, one_shot: 1'b1};
            4'd9, 4'd11:                     a = '{can_start: 1'b1, needs_pen: 1'b0, one_shot: 1'b0};
            default:                         a = '{can_start: 1'b0, needs_pen: 1'b0, one_shot: 1'b0};
        endcase
        return a;
    endfunction

    // Data-available bits produced by a finished burst of each function.
    function automatic logic [WORD_W-1:0] fn_mask(input logic [FUNC_W-1:0] f);
        logic [WORD_W-1:0] m;
        case (f)
            4'd1:        m = 16'h0600;
            4'd2:        m = 16'h0780;
            4'd3:        m = 16'h0400;
            4'd4:        m = 16'h0200;
            4'd5:        m = 16'h0180;
            4'd6:        m = 16'h0040;
            4'd7:        m = 16'h0030;
            4'd8, 4'd9:  m = 16'h0010;
            4'd10:       m = 16'h0004;
            4'd11:       m = 16'h0070;
            4'd12:       m = 16'h0002;
            default:     m = 16'h0000;
        endcase
        return m;
    endfunction

    // Result width in bits for a resolution index.
    function automatic logic [BITS_W-1:0] res_bits(input logic [RES_W-1:0] r);
        logic [BITS_W-1:0] b;
        case (r)
            2'd1:    b = 5'd8;
            2'd2:    b = 5'd10;
            default: b = 5'd12;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/adc_ctl_regs.sv
// Host-visible control state: enable, pending function/resolution, filter,
// host bit and interrupt pin mode.
// Assumes soft_rst and the write strobes are single-cycle and synchronous to clk.
// A control write has priority over the single-shot disable in the same cycle.
module adc_ctl_regs
    import adc_seq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                soft_rst,
    input  logic                ctl_wr,
    input  logic [WORD_W-1:0]   ctl_data,
    input  logic                pin_wr,
    input  logic [PMODE_W-1:0]  pin_data,
    input  logic                shot_off,
    output logic                en_q,
    output logic                host_q,
    output logic [FUNC_W-1:0]   next_func_q,
    output logic [RES_W-1:0]    next_res_q,
    output logic [FILT_W-1:0]   filt_q,
    output pin_mode_e           pmode_q
);

    // Control word fields and the enable, including the single-shot disable.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            en_q        <= 1'b0;
            host_q      <= 1'b0;
            next_func_q <= '0;
            next_res_q  <= '0;
            filt_q      <= '0;
        end else if (ctl_wr) begin
            en_q        <= ~ctl_data[14];
            host_q      <= ctl_data[15];
            next_func_q <= ctl_data[13:10];
            next_res_q  <= ctl_data[9:8];
            filt_q      <= ctl_data[7:0];
        end else if (shot_off) begin
            en_q        <= 1'b0;
        end
    end

    // Interrupt pin mode.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            pmode_q <= PIN_PEN_IDLE;
        end else if (pin_wr) begin
            pmode_q <= pin_mode_e'(pin_data);
        end
    end

endmodule

// File: rtl/adc_start_rules.sv
// Combinational start decision and single-shot disable for the pending function.
// Assumes every input comes from registers or synchronous ports. hold blocks a
// start in cycles that rewrite the control state.
module adc_start_rules
    import adc_seq_pkg::*;
(
    input  logic [FUNC_W-1:0]  func,
    input  logic               pen,
    input  logic               en,
    input  logic               busy,
    input  logic [WORD_W-1:0]  avail,
    input  logic               hold,
    output logic               start,
    output logic               shot_off
);

    fn_attr_t attr;
    logic     pen_ok;
    logic     pending;

    // Classify the function and evaluate both decisions.
    always_comb begin
        attr     = fn_attr(func);
        pen_ok   = !attr.needs_pen || pen;
        pending  = |avail;
        start    = attr.can_start && pen_ok && en && !busy && !pending && !hold;
        shot_off = attr.one_shot && pen_ok && pending;
    end

endmodule

// File: rtl/adc_burst_timer.sv
// Busy interval counter with latching of the active function and resolution.
// Assumes BUSY_CYCLES >= 2. abort has priority over completion; start is never
// raised while busy.
module adc_burst_timer
    import adc_seq_pkg::*;
#(
    parameter int BUSY_CYCLES = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               abort,
    input  logic [FUNC_W-1:0]  next_func,
    input  logic [RES_W-1:0]   next_res,
    output logic               busy_q,
    output logic               done,
    output logic [FUNC_W-1:0]  act_func_q,
    output logic [RES_W-1:0]   act_res_q
);

    localparam int CNT_W = (BUSY_CYCLES > 2) ? $clog2(BUSY_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BUSY_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    // The final busy cycle is the one in which the counter reaches zero.
    assign done = busy_q && (cnt_q == '0);

    // Busy flag and down counter.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= LAST;
        end else if (done) begin
            busy_q <= 1'b0;
        end else if (busy_q) begin
            cnt_q  <= cnt_q - 1'b1;
        end
    end

    // Active function and resolution, captured at burst start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_func_q <= '0;
            act_res_q  <= '0;
        end else if (start) begin
            act_func_q <= next_func;
            act_res_q  <= next_res;
        end
    end

endmodule

// File: rtl/adc_irq_pin.sv
// Registered active-low interrupt pin with a selectable source.
// Assumes pen is synchronous; output is gated by the enable one cycle later.
module adc_irq_pin
    import adc_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               soft_rst,
    input  logic               en,
    input  logic               pen,
    input  logic [WORD_W-1:0]  avail,
    input  pin_mode_e          pmode,
    output logic               irq_n
);

    logic src;
    logic irq_q;

    // Select the interrupt source from the pin mode.
    always_comb begin
        case (pmode)
            PIN_PEN:  src = pen;
            PIN_DATA: src = |avail;
            default:  src = pen && !(|avail);
        endcase
    end

    // Register the gated source.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= en && src;
        end
    end

    assign irq_n = ~irq_q;

endmodule

// File: rtl/adc_seq_core.sv
// Top of the conversion sequencer: joins the control registers, start rules,
// burst timer and interrupt pin, and keeps the data-available vector.
// Assumes all inputs are synchronous to clk. A soft reset or control write wins
// over a burst start in the same cycle.
module adc_seq_core
    import adc_seq_pkg::*;
#(
    parameter int BUSY_CYCLES = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pen_down,
    input  logic                ctl_wr,
    input  logic [WORD_W-1:0]   ctl_data,
    input  logic                pin_wr,
    input  logic [PMODE_W-1:0]  pin_data,
    input  logic                key_wr,
    input  logic [WORD_W-1:0]   key_data,
    input  logic [WORD_W-1:0]   rd_clear,
    output logic                busy,
    output logic [WORD_W-1:0]   avail,
    output logic                irq_n,
    output logic [FUNC_W-1:0]   act_func,
    output logic [RES_W-1:0]    act_res,
    output logic [BITS_W-1:0]   act_bits,
    output logic [WORD_W-1:0]   status,
    output logic                host_ctl
);

    logic               soft_rst;
    logic               abort_w;
    logic               hold;
    logic               start;
    logic               shot_off;
    logic               done;
    logic               en_q;
    logic [FUNC_W-1:0]  next_func;
    logic [RES_W-1:0]   next_res;
    logic [FILT_W-1:0]  filt;
    pin_mode_e          pmode;
    logic [WORD_W-1:0]  avail_q;

    assign soft_rst = key_wr && (key_data == RESET_KEY);
    assign abort_w  = soft_rst || (ctl_wr && ctl_data[14]);
    assign hold     = soft_rst || ctl_wr;

    adc_ctl_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .soft_rst    (soft_rst),
        .ctl_wr      (ctl_wr),
        .ctl_data    (ctl_data),
        .pin_wr      (pin_wr),
        .pin_data    (pin_data),
        .shot_off    (shot_off),
        .en_q        (en_q),
        .host_q      (host_ctl),
        .next_func_q (next_func),
        .next_res_q  (next_res),
        .filt_q      (filt),
        .pmode_q     (pmode)
    );

    adc_start_rules u_rules (
        .func     (next_func),
        .pen      (pen_down),
        .en       (en_q),
        .busy     (busy),
        .avail    (avail_q),
        .hold     (hold),
        .start    (start),
        .shot_off (shot_off)
    );

    adc_burst_timer #(
        .BUSY_CYCLES (BUSY_CYCLES)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .abort      (abort_w),
        .next_func  (next_func),
        .next_res   (next_res),
        .busy_q     (busy),
        .done       (done),
        .act_func_q (act_func),
        .act_res_q  (act_res)
    );

    adc_irq_pin u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .en       (en_q),
        .pen      (pen_down),
        .avail    (avail_q),
        .pmode    (pmode),
        .irq_n    (irq_n)
    );

    // Data-available: clear strobes drop bits, a completed burst ORs in its mask.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            avail_q <= '0;
        end else begin
            avail_q <= (avail_q & ~rd_clear) |
                       ((done && !abort_w) ? fn_mask(act_func) : '0);
        end
    end

    assign avail    = avail_q;
    assign act_bits = res_bits(act_res);
    assign status   = {pen_down, ~busy, next_func, next_res, filt};

endmodule

// File: rtl/adc_seq_checker.sv
// Temporal checks on the sequencer, bound into adc_seq_core.
module adc_seq_checker
    import adc_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               busy,
    input  logic               abort,
    input  logic               irq_n,
    input  logic [WORD_W-1:0]  avail,
    input  logic [FUNC_W-1:0]  act_func
);

    // R4: a burst that ends without an abort always leaves data pending.
    a_r4_done_sets_data: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !$past(abort)) |-> (avail != '0));

    // R3: a burst only starts from a state with no data pending.
    a_r3_start_when_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(avail) == '0));

    // R11: a disabled block leaves the pin high on the next cycle.
    a_r11_irq_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> irq_n);

    // R9: an abort drops busy on the next cycle.
    a_r9_abort_clears_busy: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !busy);

    // R5: the active function holds during a burst.
    a_r5_active_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(act_func));

endmodule

bind adc_seq_core adc_seq_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en_q),
    .busy     (busy),
    .abort    (abort_w),
    .irq_n    (irq_n),
    .avail    (avail),
    .act_func (act_func)
);

// File: tb/sim_adc_seq_core.sv
`timescale 1ns/1ps
module sim_adc_seq_core;

    localparam int B = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pen_down = 1'b0;
    logic        ctl_wr = 1'b0;
    logic [15:0] ctl_data = '0;
    logic        pin_wr = 1'b0;
    logic [1:0]  pin_data = '0;
    logic        key_wr = 1'b0;
    logic [15:0] key_data = '0;
    logic [15:0] rd_clear = '0;
    logic        busy;
    logic [15:0] avail;
    logic        irq_n;
    logic [3:0]  act_func;
    logic [1:0]  act_res;
    logic [4:0]  act_bits;
    logic [15:0] status;
    logic        host_ctl;

    int n_cmp = 0;
    int n_bad = 0;
    bit done_flag = 1'b0;

    always #4 clk = ~clk;

    adc_seq_core #(.BUSY_CYCLES(B)) u0 (
        .clk(clk), .rst_n(rst_n), .pen_down(pen_down),
        .ctl_wr(ctl_wr), .ctl_data(ctl_data),
        .pin_wr(pin_wr), .pin_data(pin_data),
        .key_wr(key_wr), .key_data(key_data),
        .rd_clear(rd_clear),
        .busy(busy), .avail(avail), .irq_n(irq_n),
        .act_func(act_func), .act_res(act_res), .act_bits(act_bits),
        .status(status), .host_ctl(host_ctl)
    );

    // {function[3:0], pen, expected data-available[15:0]}
    localparam logic [20:0] VEC [20] = '{
        {4'd0,  1'b1, 16'h0000}, {4'd1,  1'b1, 16'h0600}, {4'd1,  1'b0, 16'h0000},
        {4'd2,  1'b1, 16'h0780}, {4'd2,  1'b0, 16'h0000}, {4'd3,  1'b1, 16'h0400},
        {4'd3,  1'b0, 16'h0000}, {4'd4,  1'b1, 16'h0200}, {4'd5,  1'b1, 16'h0180},
        {4'd5,  1'b0, 16'h0000}, {4'd6,  1'b0, 16'h0040}, {4'd7,  1'b0, 16'h0030},
        {4'd8,  1'b0, 16'h0010}, {4'd9,  1'b0, 16'h0010}, {4'd10, 1'b0, 16'h0004},
        {4'd11, 1'b0, 16'h0070}, {4'd12, 1'b0, 16'h0002}, {4'd13, 1'b1, 16'h0000},
        {4'd14, 1'b1, 16'h0000}, {4'd15, 1'b1, 16'h0000}
    };

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_ctl(input logic [15:0] v);
        ctl_wr = 1'b1; ctl_data = v;
        @(negedge clk);
        ctl_wr = 1'b0; ctl_data = '0;
    endtask

    task automatic wr_key(input logic [15:0] v);
        key_wr = 1'b1; key_data = v;
        @(negedge clk);
        key_wr = 1'b0; key_data = '0;
    endtask

    task automatic wr_pin(input logic [1:0] v);
        pin_wr = 1'b1; pin_data = v;
        @(negedge clk);
        pin_wr = 1'b0;
    endtask

    task automatic pulse_clear(input logic [15:0] v);
        rd_clear = v;
        @(negedge clk);
        rd_clear = '0;
    endtask

    function automatic logic [4:0] exp_bits(input int r);
        case (r)
            1: return 5'd8;
            2: return 5'd10;
            default: return 5'd12;
        endcase
    endfunction

    initial begin
        #(8 * 200000);
        if (!done_flag) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int busy_cnt;
        tick(4);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 avail", avail, 0);
        chk("R1 irq_n", irq_n, 1);
        chk("R1 status", status, 16'h4000);

        // Table walk: R3 start classes and R4 masks
        for (int k = 0; k < 20; k++) begin
            wr_key(16'hBB00);
            pen_down = VEC[k][16];
            wr_ctl({2'b00, VEC[k][20:17], 2'b00, 8'h00});
            tick(B + 4);
            chk($sformatf("R3/R4 func %0d pen %0d avail", VEC[k][20:17], VEC[k][16]),
                avail, VEC[k][15:0]);
            chk("R4 busy idle", busy, 0);
        end

        // R2 field decode, disabled, host bit kept
        wr_key(16'hBB00);
        pen_down = 1'b0;
        wr_ctl(16'hD6A5);
        tick(B);
        chk("R2 status", status, 16'h56A5);
        chk("R2 host_ctl", host_ctl, 1);
        chk("R2 no start while disabled", busy, 0);

        // R4 busy length, R2 not-busy bit, R5 active capture
        wr_key(16'hBB00);
        wr_ctl(16'h2500);
        busy_cnt = 0;
        for (int i = 0; i < 2 * B + 4; i++) begin
            if (busy) busy_cnt++;
            if (i == 3) chk("R2 status busy bit", status[14], 0);
            tick(1);
        end
        chk("R4 busy cycles", busy_cnt, B);
        chk("R4 avail func 9", avail, 16'h0010);
        chk("R5 act_func", act_func, 9);
        chk("R5 act_res", act_res, 1);
        chk("R5 act_bits", act_bits, 8);

        // R5 resolution widths
        for (int r = 0; r < 4; r++) begin
            wr_key(16'hBB00);
            wr_ctl({6'b001001, r[1:0], 8'h00});
            tick(B + 4);
            chk($sformatf("R5 bits res %0d", r), act_bits, exp_bits(r));
        end

        // R7 clear only the named bit
        wr_key(16'hBB00);
        pen_down = 1'b1;
        wr_ctl(16'h0800);
        tick(B + 4);
        chk("R7 before clear", avail, 16'h0780);
        pulse_clear(16'h0400);
        chk("R7 after clear", avail, 16'h0380);

        // R6 single-shot stops, continuous restarts
        wr_key(16'hBB00);
        pen_down = 1'b0;
        wr_ctl(16'h1800);
        tick(B + 4);
        chk("R6 one-shot data", avail, 16'h0040);
        pulse_clear(16'h0040);
        tick(B + 4);
        chk("R6 one-shot no restart", avail, 16'h0000);
        wr_key(16'hBB00);
        wr_ctl(16'h2400);
        tick(B + 4);
        pulse_clear(16'h0010);
        tick(B + 4);
        chk("R6 continuous restart", avail, 16'h0010);

        // R8 interrupt modes
        wr_key(16'hBB00);
        pen_down = 1'b1;
        wr_ctl(16'h0000);
        tick(3);
        chk("R8 mode2 pen idle", irq_n, 0);
        pen_down = 1'b0;
        tick(3);
        chk("R8 mode2 pen up", irq_n, 1);
        wr_pin(2'd0);
        pen_down = 1'b1;
        tick(3);
        chk("R8 mode0 pen", irq_n, 0);
        wr_pin(2'd1);
        tick(3);
        chk("R8 mode1 no data", irq_n, 1);
        pen_down = 1'b0;
        wr_ctl(16'h2400);
        tick(B + 4);
        chk("R8 mode1 data", irq_n, 0);
        wr_pin(2'd2);
        pen_down = 1'b1;
        tick(3);
        chk("R8 mode2 data pending", irq_n, 1);

        // R11 disabled holds the pin high
        wr_pin(2'd0);
        wr_ctl(16'h4000);
        tick(3);
        chk("R11 disabled irq", irq_n, 1);

        // R9 abort
        wr_key(16'hBB00);
        pen_down = 1'b0;
        wr_ctl(16'h2400);
        tick(4);
        chk("R9 busy before abort", busy, 1);
        wr_ctl(16'h6400);
        chk("R9 busy after abort", busy, 0);
        tick(B + 4);
        chk("R9 no data after abort", avail, 16'h0000);

        // R10 wrong key ignored, right key resets
        wr_key(16'hBB00);
        wr_pin(2'd1);
        wr_ctl(16'h56A5);
        wr_key(16'hBB01);
        tick(1);
        chk("R10 wrong key status", status, 16'h56A5);
        wr_key(16'hBB00);
        tick(1);
        chk("R10 key reset status", status, 16'h4000);
        pen_down = 1'b1;
        wr_ctl(16'h0000);
        tick(3);
        chk("R10 pin mode back to 2", irq_n, 0);

        done_flag = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule